// File: doc/BRIEF.md
# Strobe-Captured One-of-Sixteen Selector

This block holds a 4-bit code in a register gated by a strobe and turns the held code into one active line out of sixteen. The strobe and the code are sampled on the system clock. While the sampled strobe is high, the held code tracks the sampled code. Once the strobe drops, the held code stays frozen at the value sampled in the last high cycle. A blanking input drives every output to its idle level at once, without passing through any register. A build-time choice sets the output sense: either the chosen line is 1 and the rest 0, or the chosen line is 0 and the rest 1.

Two build-time limits, counted in clock cycles, set the shortest allowed strobe-high pulse and how long the code must stay unchanged before the strobe falls. If either rule is broken at a falling strobe, a sticky flag is raised and stays up until reset. The strobe and code inputs can pass through a two-stage synchronizer, or through a single sampling register when they already belong to the clock domain. All pins are plain level signals, with no handshake and no back-pressure.

Top module: `strobe_decoder`

## Requirements
- R1: The code is the unsigned value of `data_i`, with `data_i[0]` weighing 1 and `data_i[3]` weighing 8.
- R2: At each clock edge where the sampled strobe is 1, the held code loads the sampled code. While the sampled strobe is 0, the held code does not change, so data changes during that time have no effect on the outputs.
- R3: With `inhibit_i` low, exactly one output is active, and it is `sel_o[n]` where n is the held code.
- R4: While `inhibit_i` is 1, every output sits at its idle level in the same cycle, whatever the strobe and data do. Loading of the held code continues, so releasing `inhibit_i` shows the current held code.
- R5: With `POLARITY = POL_ACTIVE_HIGH`, the active output is 1, the others are 0, and inhibit gives all zeros. With `POL_ACTIVE_LOW`, the active output is 0, the others are 1, and inhibit gives all ones.
- R6: A synchronous reset (`rst` high) clears the held code to 0 and clears the synchronizer, so after reset `sel_o` selects line 0 unless inhibited.
- R7: `timing_err_o` rises when the sampled strobe falls after fewer than `MIN_PULSE_CYC` consecutive high samples.
- R8: `timing_err_o` rises when the sampled code changed fewer than `SETUP_CYC` cycles before the sampled strobe falls. Pulses that obey both limits never raise it.
- R9: `timing_err_o` stays at 1 until reset clears it.
- R10: With `SYNC_EN = 1`, a code driven while the strobe is high shows on `sel_o` after the third rising clock edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_i | input | 1 | Load enable for the held code |
| data_i | input | 4 | Code to be held and decoded |
| inhibit_i | input | 1 | Forces all outputs idle, acting without a register |
| sel_o | output | 16 | One-of-sixteen select lines |
| timing_err_o | output | 1 | Sticky flag for strobe width or data setup violations |

## Verification
The assertions on held-code loading and holding refer to the synchronized strobe and code. They therefore assume nothing about how the raw inputs line up with the clock. The bench still changes every input half a period away from the rising edge, so each value is sampled once and without ambiguity. The one-hot and idle-level checks expect `inhibit_i` to be a clean level at each edge. The violation stimulus uses single-cycle pulses and code changes one cycle before the fall, both well inside the default limits of two cycles, and every legal strobe runs for four cycles with the code settled. Any flag that appears is therefore caused by the intended violation alone.

// File: rtl/strobe_dec_pkg.sv
package strobe_dec_pkg;

  typedef enum logic {
    POL_ACTIVE_LOW  = 1'b0,
    POL_ACTIVE_HIGH = 1'b1
  } polarity_e;

  localparam int unsigned DEF_CODE_W = 4;

endpackage

// File: rtl/sdec_input_sync.sv
module sdec_input_sync #(
  parameter int unsigned WIDTH   = 5,
  parameter bit          SYNC_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  localparam int unsigned STAGES = SYNC_EN ? 2 : 1;

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/sdec_hold_reg.sv
module sdec_hold_reg #(
  parameter int unsigned CODE_W        = 4,
  parameter int unsigned SETUP_CYC     = 2,
  parameter int unsigned MIN_PULSE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strb,
  input  logic [CODE_W-1:0] data,
  output logic [CODE_W-1:0] code,
  output logic              timing_err
);

  localparam int unsigned SW = $clog2(SETUP_CYC + 1) + 1;
  localparam int unsigned PW = $clog2(MIN_PULSE_CYC + 1) + 1;
  localparam logic [SW-1:0] SETUP_LIM = SW'(SETUP_CYC);
  localparam logic [PW-1:0] PULSE_LIM = PW'(MIN_PULSE_CYC);

  logic              strb_d;
  logic [CODE_W-1:0] data_d;
  logic [SW-1:0]     since_chg;
  logic [PW-1:0]     hi_cnt;
  logic              fall;
  logic              short_pulse;
  logic              late_data;

  // held code
  always_ff @(posedge clk) begin
    if (rst)       code <= '0;
    else if (strb) code <= data;
  end

  // history for the timing checks
  always_ff @(posedge clk) begin
    if (rst) begin
      strb_d    <= 1'b0;
      data_d    <= '0;
      since_chg <= SETUP_LIM;
      hi_cnt    <= '0;
    end else begin
      strb_d <= strb;
      data_d <= data;
      if (data != data_d)          since_chg <= '0;
      else if (since_chg < SETUP_LIM) since_chg <= since_chg + 1'b1;
      if (!strb)                   hi_cnt <= '0;
      else if (hi_cnt < PULSE_LIM) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  assign fall        = strb_d & ~strb;
  assign short_pulse = hi_cnt < PULSE_LIM;
  assign late_data   = since_chg < SETUP_LIM;

  always_ff @(posedge clk) begin
    if (rst)       timing_err <= 1'b0;
    else if (fall && (short_pulse || late_data)) timing_err <= 1'b1;
  end

  AST_FOLLOW_WHILE_HIGH: assert property (@(posedge clk) disable iff (rst)
    strb |=> (code == $past(data)));  // R2
  AST_HOLD_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
    !strb |=> $stable(code));  // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    timing_err |=> timing_err);  // R9
  AST_FLAG_ONLY_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    (!timing_err && !fall) |=> !timing_err);  // R7

endmodule

// File: rtl/sdec_onehot.sv
module sdec_onehot
  import strobe_dec_pkg::*;
#(
  parameter int unsigned CODE_W   = 4,
  parameter polarity_e   POLARITY = POL_ACTIVE_HIGH
) (
  input  logic [CODE_W-1:0]      code,
  input  logic                   inhibit,
  output logic [(1<<CODE_W)-1:0] sel
);

  localparam int unsigned N_OUT = 1 << CODE_W;

  logic [N_OUT-1:0] hit;

  for (genvar i = 0; i < N_OUT; i++) begin : g_line
    assign hit[i] = (code == CODE_W'(i));
  end

  if (POLARITY == POL_ACTIVE_HIGH) begin : g_pos
    assign sel = inhibit ? '0 : hit;
  end else begin : g_neg
    assign sel = inhibit ? '1 : ~hit;
  end

endmodule

// File: rtl/strobe_decoder.sv
module strobe_decoder
  import strobe_dec_pkg::*;
#(
  parameter int unsigned CODE_W        = DEF_CODE_W,
  parameter polarity_e   POLARITY      = POL_ACTIVE_HIGH,
  parameter bit          SYNC_EN       = 1'b1,
  parameter int unsigned SETUP_CYC     = 2,
  parameter int unsigned MIN_PULSE_CYC = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   strobe_i,
  input  logic [CODE_W-1:0]      data_i,
  input  logic                   inhibit_i,
  output logic [(1<<CODE_W)-1:0] sel_o,
  output logic                   timing_err_o
);

  localparam int unsigned N_OUT = 1 << CODE_W;

  logic [CODE_W:0]   samp;
  logic              strb_s;
  logic [CODE_W-1:0] data_s;
  logic [CODE_W-1:0] held;
  logic [N_OUT-1:0]  act_view;

  sdec_input_sync #(
    .WIDTH   (CODE_W + 1),
    .SYNC_EN (SYNC_EN)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({strobe_i, data_i}),
    .dout (samp)
  );

  assign strb_s = samp[CODE_W];
  assign data_s = samp[CODE_W-1:0];

  sdec_hold_reg #(
    .CODE_W        (CODE_W),
    .SETUP_CYC     (SETUP_CYC),
    .MIN_PULSE_CYC (MIN_PULSE_CYC)
  ) u_hold (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb_s),
    .data       (data_s),
    .code       (held),
    .timing_err (timing_err_o)
  );

  sdec_onehot #(
    .CODE_W   (CODE_W),
    .POLARITY (POLARITY)
  ) u_dec (
    .code    (held),
    .inhibit (inhibit_i),
    .sel     (sel_o)
  );

  assign act_view = (POLARITY == POL_ACTIVE_HIGH) ? sel_o : ~sel_o;

  AST_SINGLE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    !inhibit_i |-> ($countones(act_view) == 1 && act_view[held]));  // R3
  AST_INHIBIT_IDLE: assert property (@(posedge clk) disable iff (rst)
    inhibit_i |-> (act_view == '0));  // R4
  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (held == '0 && !timing_err_o));  // R6

endmodule

// File: tb/test_strobe_decoder.sv
module test_strobe_decoder;
  import strobe_dec_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strobe_i = 1'b0;
  logic [3:0]  data_i = '0;
  logic        inhibit_i = 1'b0;
  logic [15:0] sel_hi, sel_lo;
  logic        err_hi, err_lo;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  strobe_decoder #(.POLARITY(POL_ACTIVE_HIGH)) i_strobe_decoder (
    .clk(clk), .rst(rst), .strobe_i(strobe_i), .data_i(data_i),
    .inhibit_i(inhibit_i), .sel_o(sel_hi), .timing_err_o(err_hi));

  strobe_decoder #(.POLARITY(POL_ACTIVE_LOW)) i_strobe_decoder_lo (
    .clk(clk), .rst(rst), .strobe_i(strobe_i), .data_i(data_i),
    .inhibit_i(inhibit_i), .sel_o(sel_lo), .timing_err_o(err_lo));

  localparam logic [3:0] CODES [16] =
    '{4'd5, 4'd0, 4'd15, 4'd8, 4'd1, 4'd14, 4'd2, 4'd13,
      4'd3, 4'd12, 4'd4, 4'd11, 4'd6, 4'd9, 4'd7, 4'd10};

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_sel(input string tag, input logic [3:0] code);
    logic [15:0] e;
    e = 16'(1) << code;
    chk({tag, " high"}, sel_hi, e);
    chk({tag, " low"}, sel_lo, ~e);
  endtask

  task automatic chk_err(input string tag, input logic exp);
    chk({tag, " flag high"}, {15'd0, err_hi}, {15'd0, exp});
    chk({tag, " flag low"}, {15'd0, err_lo}, {15'd0, exp});
  endtask

  initial begin
    // R6: reset with strobe high still selects line 0
    strobe_i = 1'b1; data_i = 4'd9;
    step(3);
    chk_sel("R6 during reset", 4'd0);
    strobe_i = 1'b0;
    step(3);
    rst = 1'b0;
    step(1);
    chk_sel("R6 after reset", 4'd0);
    chk_err("R6 after reset", 1'b0);

    // R1 R3 R5: every code in both polarities
    for (int k = 0; k < 16; k++) begin
      data_i = CODES[k]; strobe_i = 1'b1;
      step(4);
      strobe_i = 1'b0;
      step(4);
      chk_sel($sformatf("R1 R3 R5 code %0d", CODES[k]), CODES[k]);
    end
    chk_err("R8 clean strobes", 1'b0);

    // R2: changes while strobe low are ignored
    data_i = 4'd3;  step(2); chk_sel("R2 low ignore a", 4'd10);
    data_i = 4'd15; step(2); chk_sel("R2 low ignore b", 4'd10);
    data_i = 4'd0;  step(2); chk_sel("R2 low ignore c", 4'd10);

    // R10: latency through two-stage sync
    data_i = 4'd6; strobe_i = 1'b1;
    step(2); chk_sel("R10 not after two edges", 4'd10);
    step(1); chk_sel("R10 after three edges", 4'd6);
    // R2: follows while high, then holds
    data_i = 4'd12; step(4); chk_sel("R2 follow high", 4'd12);
    strobe_i = 1'b0; step(4); chk_sel("R2 hold after fall", 4'd12);

    // R4: inhibit acts in the same cycle, does not disturb loading
    inhibit_i = 1'b1; #1;
    chk("R4 R5 inhibit high", sel_hi, 16'h0000);
    chk("R4 R5 inhibit low", sel_lo, 16'hFFFF);
    step(1);
    data_i = 4'd7; strobe_i = 1'b1; step(4);
    chk("R4 inhibit strobe high", sel_hi, 16'h0000);
    chk("R4 inhibit strobe low", sel_lo, 16'hFFFF);
    strobe_i = 1'b0; step(4);
    data_i = 4'd1; step(2);
    inhibit_i = 1'b0; #1;
    chk_sel("R4 release shows held", 4'd7);
    chk_err("R7 R8 no false flag", 1'b0);
    step(1);

    // R7: single-cycle strobe pulse
    data_i = 4'd1; strobe_i = 1'b1; step(1);
    strobe_i = 1'b0; step(4);
    chk_err("R7 short pulse", 1'b1);
    // R9: stays set after a legal pulse
    data_i = 4'd2; strobe_i = 1'b1; step(4);
    strobe_i = 1'b0; step(4);
    chk_err("R9 sticky", 1'b1);
    chk_sel("R9 decode unaffected", 4'd2);
    rst = 1'b1; step(2); rst = 1'b0; step(1);
    chk_err("R9 reset clears", 1'b0);
    chk_sel("R6 second reset", 4'd0);

    // R8: code change one cycle before the fall
    data_i = 4'd5; strobe_i = 1'b1; step(5);
    data_i = 4'd9; step(1);
    strobe_i = 1'b0; step(4);
    chk_err("R8 late data", 1'b1);
    chk_sel("R2 last high sample held", 4'd9);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule